// File: doc/BRIEF.md
# Multiplexed Byte-Bus Register Slave

This block connects an external host to an internal register file over an 8-bit bus that carries the register address first and then the data byte. The host puts an address on the shared lines and pulses the address strobe high. The falling edge of that strobe fixes the address. The host then reads or writes one byte using three active-low strobes: chip select, read and write. All host pins are asynchronous to the block clock. They pass through a synchronizer chain, and the bus byte goes through a chain of the same depth, so each sampled byte stays aligned with the strobe state it belongs to.

Inside the chip the block gives a plain register port: an address, a write byte, a one-cycle write enable, a one-cycle read enable and a read byte. The read enable fires once when a read starts, so clear-on-read side effects act only once. The read byte is captured at that pulse and held on the bus output for the rest of the read. The output enable for the shared lines is high only while chip select and read are both low. A write commits when either write or chip select goes back high. If read and write are low together, the write is dropped and the read goes ahead.

Top module: `mux_bus_regslave`

## Requirements
- R1: While reset is held, reg_we, reg_re and ad_oe are 0 and reg_addr is 0x00.
- R2: reg_addr takes the byte that was on ad_in while ale was high, as seen at ale's falling edge. Changes on ad_in after ale is low do not alter reg_addr.
- R3: Each completed write gives exactly one reg_we pulse of one clock. During that pulse, reg_addr holds the latched address and reg_wdata holds the byte that was on ad_in while cs_n and wr_n were both low.
- R4: With cs_n held low, a write completes when wr_n returns high.
- R5: With wr_n held low, a write completes when cs_n returns high.
- R6: No reg_we pulse is produced while cs_n and wr_n are both still low.
- R7: Each read (cs_n and rd_n both low) gives exactly one reg_re pulse of one clock, at its start.
- R8: ad_oe is 1 while cs_n and rd_n are both low and 0 otherwise. rd_n low with cs_n high gives no ad_oe and no reg_re.
- R9: ad_out shows the reg_rdata value present at the reg_re pulse. It stays unchanged for the rest of the read, even if reg_rdata changes.
- R10: If rd_n and wr_n are both low under cs_n low, no reg_we is produced, and the read still gives its reg_re pulse.
- R11: wr_n pulsed low while cs_n stays high produces no reg_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 8 | Shared address/data lines, input side |
| ale | input | 1 | Address strobe, active high; address fixed on its fall |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_out | output | 8 | Read byte driven toward the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| reg_addr | output | 8 | Register address for the register file |
| reg_wdata | output | 8 | Write byte for the register file |
| reg_we | output | 1 | One-cycle write commit |
| reg_re | output | 1 | One-cycle read start |
| reg_rdata | input | 8 | Read byte from the register file |

## Verification
The bench ends writes in two ways, by releasing write and by releasing chip select. A design that looks for only one of these edges would miss the other kind of write, or would commit it twice. The bench changes the bus lines after the address strobe falls, to catch a design that keeps latching the address. It changes the register read value in the middle of a read, to catch a design that passes reg_rdata straight through or fires the read enable more than once. It also drives a strobe without chip select, and drives read and write low together, to catch designs that commit a write they should have dropped.

// File: rtl/mux_bus_regslave.sv
module mux_bus_regslave #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ad_in,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [DW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  localparam logic [3:0] IDLE = 4'b0111;

  logic [3:0]    st_p [SYNC];
  logic [DW-1:0] ad_p [SYNC];
  logic [DW-1:0] addr_q, wdata_q, rhold_q;
  logic          wr_act_q, rd_act_q, blk_q;

  wire [3:0]    st   = st_p[SYNC-1];
  wire [DW-1:0] ad_s = ad_p[SYNC-1];
  wire ale_s = st[3];
  wire cs_s  = st[2];
  wire rd_s  = st[1];
  wire wr_s  = st[0];

  wire wr_act = ~cs_s & ~wr_s;
  wire rd_act = ~cs_s & ~rd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) begin
        st_p[i] <= IDLE;
        ad_p[i] <= '0;
      end
    end else begin
      st_p[0] <= {ale, cs_n, rd_n, wr_n};
      ad_p[0] <= ad_in;
      for (int i = 1; i < SYNC; i++) begin
        st_p[i] <= st_p[i-1];
        ad_p[i] <= ad_p[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rhold_q  <= '0;
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      blk_q    <= 1'b0;
    end else begin
      if (ale_s)  addr_q  <= ad_s;
      if (wr_act) wdata_q <= ad_s;
      if (reg_re) rhold_q <= reg_rdata;
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      blk_q    <= wr_act & (blk_q | rd_act);
    end
  end

  assign reg_we    = wr_act_q & ~wr_act & ~blk_q & ~rd_act;
  assign reg_re    = rd_act & ~rd_act_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign ad_out    = rhold_q;
  assign ad_oe     = ~cs_n & ~rd_n;
endmodule

module mux_bus_regslave_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale,
  input logic [DW-1:0] reg_addr,
  input logic [DW-1:0] ad_out,
  input logic          ad_oe,
  input logic          reg_we,
  input logic          reg_re
);
  p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_re_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  p_no_we_in_collision_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !reg_re);
  p_addr_follows_ale_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_addr) |-> $past(ale, 3));
  p_out_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && $past(ad_oe) && !$past(reg_re)) |-> $stable(ad_out));
endmodule

bind mux_bus_regslave mux_bus_regslave_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ale(ale), .reg_addr(reg_addr),
  .ad_out(ad_out), .ad_oe(ad_oe), .reg_we(reg_we), .reg_re(reg_re)
);

// File: tb/mux_bus_regslave_tb_top.sv
module mux_bus_regslave_tb_top;
  logic       clk = 0, rst_n = 0;
  logic [7:0] ad_in = 8'h00, rmodel = 8'h00;
  logic       ale = 0, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [7:0] ad_out, reg_addr, reg_wdata, reg_rdata;
  logic       ad_oe, reg_we, reg_re;
  int tests = 0, fails = 0, we_cnt = 0, re_cnt = 0;
  logic [7:0] we_addr = 0, we_data = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign reg_rdata = reg_addr ^ rmodel;

  mux_bus_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ale(ale), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata));

  always @(negedge clk) if (rst_n) begin
    if (reg_we) begin we_cnt++; we_addr = reg_addr; we_data = reg_wdata; end
    if (reg_re) re_cnt++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(logic [7:0] a);
    @(negedge clk); ad_in = a; ale = 1;
    cyc(4); ale = 0;
    cyc(4); ad_in = 8'hEE;
    cyc(2);
  endtask

  task automatic t_reset;
    cyc(2);
    chk("R1 we", reg_we, 0); chk("R1 re", reg_re, 0);
    chk("R1 oe", ad_oe, 0);  chk("R1 addr", reg_addr, 0);
    rst_n = 1; cyc(3);
  endtask

  task automatic t_addr;
    latch(8'h3C); ad_in = 8'hFF; cyc(6);
    chk("R2 addr held", reg_addr, 8'h3C);
  endtask

  task automatic t_write(logic [7:0] a, logic [7:0] d, bit by_wr, string tag);
    int c0;
    latch(a); c0 = we_cnt;
    ad_in = d; cs_n = 0; cyc(1); wr_n = 0; cyc(8);
    chk("R6 no early we", we_cnt, c0);
    if (by_wr) wr_n = 1; else cs_n = 1;
    cyc(6); ad_in = 8'h11; cs_n = 1; wr_n = 1; cyc(6);
    chk({tag, " R3 one we"}, we_cnt, c0 + 1);
    chk({tag, " R3 addr"}, we_addr, a);
    chk({tag, " R3 data"}, we_data, d);
  endtask

  task automatic t_wr_no_cs;
    int c0 = we_cnt;
    latch(8'h07); ad_in = 8'h77; wr_n = 0; cyc(8); wr_n = 1; cyc(8);
    chk("R11 no we", we_cnt, c0);
  endtask

  task automatic t_read;
    int c0;
    rmodel = 8'h00; latch(8'h21); c0 = re_cnt;
    cs_n = 0; rd_n = 0; #1;
    chk("R8 oe on", ad_oe, 1);
    cyc(8);
    chk("R7 one re", re_cnt, c0 + 1);
    chk("R9 data", ad_out, 8'h21);
    rmodel = 8'hF0; cyc(6);
    chk("R9 held", ad_out, 8'h21);
    chk("R7 still one re", re_cnt, c0 + 1);
    rd_n = 1; cs_n = 1; #1;
    chk("R8 oe off", ad_oe, 0);
    cyc(4); rmodel = 8'h00;
  endtask

  task automatic t_rd_no_cs;
    int c0 = re_cnt;
    rd_n = 0; #1;
    chk("R8 no oe without cs", ad_oe, 0);
    cyc(8); rd_n = 1; cyc(4);
    chk("R8 no re without cs", re_cnt, c0);
  endtask

  task automatic t_collide;
    int w0, r0;
    latch(8'h55); w0 = we_cnt; r0 = re_cnt;
    ad_in = 8'h99; @(negedge clk); cs_n = 0; rd_n = 0; wr_n = 0;
    cyc(8); cs_n = 1; rd_n = 1; wr_n = 1; cyc(8);
    chk("R10 write dropped", we_cnt, w0);
    chk("R10 read kept", re_cnt, r0 + 1);
  endtask

  initial begin
    t_reset;
    t_addr;
    t_write(8'h12, 8'h5A, 1, "R4");
    t_write(8'h40, 8'hC3, 0, "R5");
    t_wr_no_cs;
    t_read;
    t_rd_no_cs;
    t_collide;
    t_write(8'hA7, 8'h3E, 1, "R4 again");
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule